// File: doc/BRIEF.md
# Converter Power State Controller

This block decides, cycle by cycle, which analog sections of a serial successive-approximation converter are powered. It watches the two-bit power field of each accepted control byte, the detection of a start bit, the end of each conversion, an active-low hardware shutdown pin and the power-on reset. From these it drives enables for the reference, the comparator (with a separate full-bias select) and the conversion core. It also raises a ready flag once every counted settling delay has run out on a free-running system clock. Current levels are not modelled. Each power condition appears only as an enable pattern and a two-bit code on `eff_mode`.

A requested low-power mode does not act at once. It is stored, and it is applied only when the conversion in progress ends. It then stays in force until another control byte replaces it. A start bit accepted while idle powers every section fully for the whole conversion. A low level on the shutdown pin overrides everything else and aborts a conversion in the same clock edge. The delays are counted in system clock cycles derived from a clock-frequency parameter: the reset interval, the wake-up time, and an optional extra wait for the internal reference to settle.

States: `ST_POR` (reset interval counting), `ST_IDLE` (between conversions, the applied mode in force), `ST_CONV` (converting, all sections on), `ST_HWSD` (hardware shutdown), `ST_WAKE` (recovering from shutdown). Transitions: any state goes to `ST_HWSD` while `shdn_n` is low. `ST_POR` goes to `ST_IDLE` when the reset count ends. `ST_IDLE` goes to `ST_CONV` on an accepted start bit. `ST_CONV` goes to `ST_IDLE` on `conv_done`. `ST_HWSD` goes to `ST_WAKE` when `shdn_n` returns high. `ST_WAKE` goes to `ST_IDLE` when the wake count ends.

Top module: `pwr_mode_mgr`

## Requirements
- R1: In idle, the applied mode code sets the enables. Code 00 turns the reference and comparator off. Code 01 and code 10 keep the reference on and the comparator on at reduced bias. Code 11 keeps both on with full bias. `eff_mode` reports the applied code.
- R2: A mode code accepted during a conversion leaves the outputs unchanged until `conv_done`. The cycle after `conv_done`, the idle enables follow the new code.
- R3: A start bit accepted in idle makes the next cycle a conversion: `core_en`, `ref_en`, `cmp_en` and `cmp_full` are all high and `eff_mode` reads 11.
- R4: A start bit is ignored when the block is not idle-and-ready, including during shutdown, wake-up and the reset interval, and during a conversion that is already running.
- R5: With `shdn_n` low, every enable and `ready` are low from the next cycle and `eff_mode` reads 00. If a conversion was running, `conv_abort` is high for exactly that one cycle.
- R6: After power-on reset, `ready` stays low for CLK_MHZ*POR_US+1 cycles with the reference and comparator fully on. The block then idles in mode 11 with `ready` high.
- R7: When `shdn_n` returns high, the reference and comparator come fully on at the next edge. `ready` rises CLK_MHZ*(WAKE_US+SETTLE_US*INT_REF_WAIT)+2 cycles after the release.
- R8: A start bit accepted while the applied mode is 00 starts the conversion at once. `ready` stays low for the first CLK_MHZ*(WAKE_US+SETTLE_US*INT_REF_WAIT) cycles of it.
- R9: A mode code presented during shutdown is discarded. The code stored before the shutdown is still applied after the next conversion.
- R10: A conversion started without a new mode code returns to the mode that was applied before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | free-running system clock |
| rst_n | input | 1 | power-on reset, active low, asynchronous |
| shdn_n | input | 1 | hardware shutdown, active low, synchronous to clk |
| start_bit | input | 1 | one-cycle pulse: a start bit was detected |
| mode_valid | input | 1 | one-cycle pulse: a control byte was accepted |
| mode_in | input | 2 | power field of that control byte (00 off, 01 fast, 10 reduced, 11 normal) |
| conv_done | input | 1 | one-cycle pulse: the conversion finished |
| ready | output | 1 | high when no settling delay is running and a conversion may start |
| core_en | output | 1 | conversion core enable, high during a conversion |
| ref_en | output | 1 | reference enable |
| cmp_en | output | 1 | comparator enable |
| cmp_full | output | 1 | comparator full-bias select (low means reduced bias) |
| eff_mode | output | 2 | power code currently in force |
| conv_abort | output | 1 | one-cycle pulse: a conversion was cut off by shutdown |

## Verification
Every cycle, the assertions check the following. Shutdown turns everything off on the next edge. An abort pulse lasts one cycle and follows a running conversion. A conversion always has every section at full power. A start that arrives while not ready is never taken. The applied idle mode never changes without a conversion in between. Leaving code 00 drops `ready`. Only the bench scenarios can show the exact counted lengths of the reset and wake delays, and the deferral of a new code to the end of its conversion. They also show that a code sent during shutdown is really lost, that modes persist across conversions, and that the 01 and 10 codes are told apart.

// File: rtl/pm_pkg.sv
package pm_pkg;

    typedef enum logic [2:0] {
        ST_POR  = 3'd0,
        ST_IDLE = 3'd1,
        ST_CONV = 3'd2,
        ST_HWSD = 3'd3,
        ST_WAKE = 3'd4
    } pm_state_e;

    localparam logic [1:0] MODE_FULLPD = 2'b00;
    localparam logic [1:0] MODE_FASTPD = 2'b01;
    localparam logic [1:0] MODE_REDP   = 2'b10;
    localparam logic [1:0] MODE_NORMAL = 2'b11;

endpackage

// File: rtl/pm_delay_timer.sv
module pm_delay_timer #(
    parameter int unsigned W       = 8,
    parameter int unsigned RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         busy
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= W'(RST_VAL);
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy = (cnt_q != '0);

endmodule

// File: rtl/pm_fsm.sv
module pm_fsm
    import pm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       shdn_n,
    input  logic       start_bit,
    input  logic       mode_valid,
    input  logic [1:0] mode_in,
    input  logic       conv_done,
    input  logic       timer_busy,
    output pm_state_e  state,
    output logic [1:0] mode_act,
    output logic       timer_load,
    output logic       conv_abort
);

    pm_state_e  state_q, state_d;
    logic [1:0] mode_q;
    logic [1:0] mode_act_q;
    logic       abort_q;
    logic       serial_live;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_POR;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and counter load
    always_comb begin
        state_d    = state_q;
        timer_load = 1'b0;
        if (!shdn_n) begin
            state_d = ST_HWSD;
        end else begin
            unique case (state_q)
                ST_POR: begin
                    if (!timer_busy) state_d = ST_IDLE;
                end
                ST_IDLE: begin
                    if (start_bit && !timer_busy) begin
                        state_d    = ST_CONV;
                        timer_load = (mode_act_q == MODE_FULLPD);
                    end
                end
                ST_CONV: begin
                    if (conv_done) state_d = ST_IDLE;
                end
                ST_HWSD: begin
                    state_d    = ST_WAKE;
                    timer_load = 1'b1;
                end
                ST_WAKE: begin
                    if (!timer_busy) state_d = ST_IDLE;
                end
                default: state_d = ST_POR;
            endcase
        end
    end

    // requested mode is held, applied mode moves only at conversion end
    assign serial_live = (state_q == ST_IDLE) || (state_q == ST_CONV) ||
                         (state_q == ST_WAKE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q     <= MODE_NORMAL;
            mode_act_q <= MODE_NORMAL;
            abort_q    <= 1'b0;
        end else begin
            abort_q <= (state_q == ST_CONV) && !shdn_n;
            if (mode_valid && serial_live && shdn_n) begin
                mode_q <= mode_in;
            end
            if (shdn_n && (state_q == ST_CONV) && conv_done) begin
                mode_act_q <= mode_q;
            end else if (shdn_n && (state_q == ST_POR) && !timer_busy) begin
                mode_act_q <= MODE_NORMAL;
            end
        end
    end

    assign state      = state_q;
    assign mode_act   = mode_act_q;
    assign conv_abort = abort_q;

endmodule

// File: rtl/pm_out_decode.sv
module pm_out_decode
    import pm_pkg::*;
(
    input  pm_state_e  state,
    input  logic [1:0] mode_act,
    input  logic       timer_busy,
    output logic       ready,
    output logic       core_en,
    output logic       ref_en,
    output logic       cmp_en,
    output logic       cmp_full,
    output logic [1:0] eff_mode
);

    always_comb begin
        core_en  = 1'b0;
        ref_en   = 1'b0;
        cmp_en   = 1'b0;
        cmp_full = 1'b0;
        eff_mode = MODE_FULLPD;
        unique case (state)
            ST_POR, ST_WAKE: begin
                ref_en   = 1'b1;
                cmp_en   = 1'b1;
                cmp_full = 1'b1;
                eff_mode = MODE_NORMAL;
            end
            ST_IDLE: begin
                eff_mode = mode_act;
                unique case (mode_act)
                    MODE_FULLPD: begin
                        ref_en = 1'b0;
                        cmp_en = 1'b0;
                    end
                    MODE_FASTPD, MODE_REDP: begin
                        ref_en = 1'b1;
                        cmp_en = 1'b1;
                    end
                    MODE_NORMAL: begin
                        ref_en   = 1'b1;
                        cmp_en   = 1'b1;
                        cmp_full = 1'b1;
                    end
                endcase
            end
            ST_CONV: begin
                core_en  = 1'b1;
                ref_en   = 1'b1;
                cmp_en   = 1'b1;
                cmp_full = 1'b1;
                eff_mode = MODE_NORMAL;
            end
            ST_HWSD: begin
                eff_mode = MODE_FULLPD;
            end
            default: begin
                eff_mode = MODE_FULLPD;
            end
        endcase
    end

    assign ready = ((state == ST_IDLE) || (state == ST_CONV)) && !timer_busy;

endmodule

// File: rtl/pwr_mode_mgr.sv
module pwr_mode_mgr
    import pm_pkg::*;
#(
    parameter int unsigned CLK_MHZ      = 100,
    parameter int unsigned POR_US       = 10,
    parameter int unsigned WAKE_US      = 2,
    parameter int unsigned SETTLE_US    = 1400,
    parameter bit          INT_REF_WAIT = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       shdn_n,
    input  logic       start_bit,
    input  logic       mode_valid,
    input  logic [1:0] mode_in,
    input  logic       conv_done,
    output logic       ready,
    output logic       core_en,
    output logic       ref_en,
    output logic       cmp_en,
    output logic       cmp_full,
    output logic [1:0] eff_mode,
    output logic       conv_abort
);

    localparam int unsigned POR_CYC  = CLK_MHZ * POR_US;
    localparam int unsigned WAKE_CYC = CLK_MHZ * (WAKE_US + (INT_REF_WAIT ? SETTLE_US : 0));
    localparam int unsigned MAX_CYC  = (POR_CYC > WAKE_CYC) ? POR_CYC : WAKE_CYC;
    localparam int unsigned CNT_W    = $clog2(MAX_CYC + 1) + 1;
    localparam logic [CNT_W-1:0] WAKE_LD = CNT_W'(WAKE_CYC);

    pm_state_e  state;
    logic [1:0] mode_act;
    logic       timer_load;
    logic       timer_busy;

    pm_delay_timer #(
        .W       (CNT_W),
        .RST_VAL (POR_CYC)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (timer_load),
        .load_val (WAKE_LD),
        .busy     (timer_busy)
    );

    pm_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .shdn_n     (shdn_n),
        .start_bit  (start_bit),
        .mode_valid (mode_valid),
        .mode_in    (mode_in),
        .conv_done  (conv_done),
        .timer_busy (timer_busy),
        .state      (state),
        .mode_act   (mode_act),
        .timer_load (timer_load),
        .conv_abort (conv_abort)
    );

    pm_out_decode u_dec (
        .state      (state),
        .mode_act   (mode_act),
        .timer_busy (timer_busy),
        .ready      (ready),
        .core_en    (core_en),
        .ref_en     (ref_en),
        .cmp_en     (cmp_en),
        .cmp_full   (cmp_full),
        .eff_mode   (eff_mode)
    );

endmodule

// File: rtl/pm_checker.sv
module pm_checker
    import pm_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       shdn_n,
    input logic       start_bit,
    input logic       ready,
    input logic       core_en,
    input logic       ref_en,
    input logic       cmp_en,
    input logic       cmp_full,
    input logic [1:0] eff_mode,
    input logic       conv_abort,
    input pm_state_e  state
);

    AST_SHDN_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !shdn_n |=> (!ref_en && !cmp_en && !core_en && !ready)); // R5

    AST_ABORT_AFTER_CONV: assert property (@(posedge clk) disable iff (!rst_n)
        conv_abort |-> (!core_en && $past(core_en))); // R5

    AST_ABORT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_abort |=> !conv_abort); // R5

    AST_CONV_FULL_POWER: assert property (@(posedge clk) disable iff (!rst_n)
        core_en |-> (ref_en && cmp_en && cmp_full && eff_mode == 2'b11)); // R3

    AST_START_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && !core_en && start_bit) |=> !core_en); // R4

    AST_IDLE_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && $past(state == ST_IDLE)) |-> $stable(eff_mode)); // R2

    AST_FULLPD_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !core_en && eff_mode == 2'b00) |-> (!ref_en && !cmp_en)); // R1

    AST_REDUCED_BIAS: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !core_en && (eff_mode == 2'b01 || eff_mode == 2'b10))
            |-> (ref_en && cmp_en && !cmp_full)); // R1

    AST_WAKE_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(core_en) && $past(eff_mode) == 2'b00) |-> !ready); // R8

endmodule

bind pwr_mode_mgr pm_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .shdn_n     (shdn_n),
    .start_bit  (start_bit),
    .ready      (ready),
    .core_en    (core_en),
    .ref_en     (ref_en),
    .cmp_en     (cmp_en),
    .cmp_full   (cmp_full),
    .eff_mode   (eff_mode),
    .conv_abort (conv_abort),
    .state      (state)
);

// File: tb/sim_pwr_mode_mgr.sv
module sim_pwr_mode_mgr;

    localparam int MHZ   = 2;
    localparam int POR_C = MHZ * 10;
    localparam int WK_C  = MHZ * (2 + 1400);

    // expected vectors {ready, core_en, ref_en, cmp_en, cmp_full, eff_mode, conv_abort}
    localparam logic [7:0] V_POR   = 8'b0011_1110;
    localparam logic [7:0] V_NORM  = 8'b1011_1110;
    localparam logic [7:0] V_CONV  = 8'b1111_1110;
    localparam logic [7:0] V_CONVW = 8'b0111_1110;
    localparam logic [7:0] V_OFF   = 8'b1000_0000;
    localparam logic [7:0] V_FAST  = 8'b1011_0010;
    localparam logic [7:0] V_RED   = 8'b1011_0100;
    localparam logic [7:0] V_ABORT = 8'b0000_0001;
    localparam logic [7:0] V_HWSD  = 8'b0000_0000;
    localparam logic [7:0] V_WAKE  = 8'b0011_1110;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic shdn_n = 1'b1;
    logic start_bit = 1'b0;
    logic mode_valid = 1'b0;
    logic [1:0] mode_in = 2'b00;
    logic conv_done = 1'b0;
    logic ready, core_en, ref_en, cmp_en, cmp_full, conv_abort;
    logic [1:0] eff_mode;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    pwr_mode_mgr #(.CLK_MHZ(MHZ)) u0 (
        .clk(clk), .rst_n(rst_n), .shdn_n(shdn_n), .start_bit(start_bit),
        .mode_valid(mode_valid), .mode_in(mode_in), .conv_done(conv_done),
        .ready(ready), .core_en(core_en), .ref_en(ref_en), .cmp_en(cmp_en),
        .cmp_full(cmp_full), .eff_mode(eff_mode), .conv_abort(conv_abort)
    );

    wire [7:0] obs = {ready, core_en, ref_en, cmp_en, cmp_full, eff_mode, conv_abort};

    typedef struct {
        string      req;
        logic [7:0] vec;
    } exp_t;

    exp_t sb_q[$];

    task automatic push_exp(input string req, input logic [7:0] v);
        exp_t e;
        e.req = req;
        e.vec = v;
        sb_q.push_back(e);
    endtask

    // monitor: compares queued expectations in the quiet half of the cycle
    always @(negedge clk) begin : monitor
        exp_t e;
        #2;
        while (sb_q.size() > 0) begin
            e = sb_q.pop_front();
            total++;
            if (obs !== e.vec) begin
                bad++;
                $display("FAIL %s got=%b exp=%b", e.req, obs, e.vec);
            end
        end
    end

    task automatic check_num(input string req, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s got=%0d exp=%0d", req, got, exp);
        end
    endtask

    task automatic do_start();
        start_bit = 1'b1;
        @(negedge clk); #1;
        start_bit = 1'b0;
    endtask

    task automatic do_done();
        conv_done = 1'b1;
        @(negedge clk); #1;
        conv_done = 1'b0;
    endtask

    task automatic do_mode(input logic [1:0] m);
        mode_in = m;
        mode_valid = 1'b1;
        @(negedge clk); #1;
        mode_valid = 1'b0;
    endtask

    task automatic wait_ready(input string req, input int n0, input int exp);
        int n;
        n = n0;
        while (!ready && n < 20000) begin
            @(negedge clk); #1;
            n++;
        end
        check_num(req, n, exp);
    endtask

    initial begin
        @(negedge clk); #1;
        push_exp("R6 reset state", V_POR);
        @(negedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk); #1;
        wait_ready("R6 reset interval length", 1, POR_C + 1);
        push_exp("R6 normal idle after reset", V_NORM);

        // normal start, code 00 deferred to end of conversion
        do_start();
        push_exp("R3 conversion full power", V_CONV);
        do_mode(2'b00);
        push_exp("R2 code 00 deferred during conversion", V_CONV);
        do_done();
        push_exp("R1 code 00 idle dark", V_OFF);

        // leave full power-down through a start bit
        do_start();
        push_exp("R8 start from code 00 not ready", V_CONVW);
        do_mode(2'b01);
        wait_ready("R8 wake delay inside conversion", 2, WK_C + 1);
        do_done();
        push_exp("R1 code 01 reduced bias", V_FAST);

        // mode persists without a new byte
        do_start();
        push_exp("R3 conversion from code 01", V_CONV);
        do_done();
        push_exp("R10 code 01 kept", V_FAST);

        do_start();
        do_mode(2'b10);
        do_done();
        push_exp("R1 code 10 reduced bias", V_RED);

        // extra start during a conversion
        do_start();
        do_start();
        push_exp("R4 second start during conversion", V_CONV);
        do_mode(2'b11);
        do_done();
        push_exp("R1 code 11 full idle", V_NORM);
        @(negedge clk); #1;
        push_exp("R4 no queued conversion", V_NORM);

        // shutdown aborts a conversion
        do_start();
        shdn_n = 1'b0;
        @(negedge clk); #1;
        push_exp("R5 shutdown with abort pulse", V_ABORT);
        @(negedge clk); #1;
        push_exp("R5 abort lasts one cycle", V_HWSD);
        do_mode(2'b00);
        do_start();
        push_exp("R4 start ignored in shutdown", V_HWSD);
        shdn_n = 1'b1;
        @(negedge clk); #1;
        push_exp("R7 wake state powers up", V_WAKE);
        wait_ready("R7 wake delay length", 1, WK_C + 2);
        push_exp("R7 idle after wake", V_NORM);
        do_start();
        do_done();
        push_exp("R9 code sent in shutdown discarded", V_NORM);

        @(negedge clk); #4;
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R6 watchdog got=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule